// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a host and a 256K x 1 dynamic memory whose 18-bit cell address reaches the part over 9 shared address pins. The host presents one request at a time through a valid/ready handshake. A request carries an operation code, an 18-bit address and one write data bit. The sequencer then produces the row strobe, the column strobe, the write strobe, the multiplexed address and the data-in bit. It samples the memory's data-out pin and returns the bit read, with a single-cycle `done` pulse.

The write strobe can follow one of two schedules. In an early write the strobe is already low before the column strobe falls, so the memory keeps its output off. The sequencer may then drive a shared data bus itself, and `d_oe` shows when it does. In a read-modify-write the column strobe falls with the write strobe high. The stored bit is sampled first, and only then does the write strobe fall, inside the same strobe-low window. Every delay is a parameter counted in controller clock cycles. Refresh is arranged elsewhere.

Top module: `dram_seq`

## Requirements
- R1: The row half of the address is `req_addr[8:0]` and the column half is `req_addr[17:9]`. `ma` carries the row half when the row strobe falls and the column half when the column strobe falls.
- R2: `ma` already holds the row half in the cycle before `ras_n` falls, and already holds the column half in the cycle before `cas_n` falls.
- R3: `ras_n` stays low with `cas_n` high for exactly T_RCD cycles (default 2) before `cas_n` falls. `cas_n` is never low while `ras_n` is high.
- R4: Read (op 0): `cas_n` stays low for T_CAS cycles (default 3) and `we_n` stays high for the whole access. `rd_data` takes the value `mem_q` had in the T_SAMP-th cycle of the column-strobe-low window (default 2), i.e. the value captured T_SAMP clock edges after `cas_n` falls.
- R5: Early write (op 1): `we_n` falls together with `ras_n`, before `cas_n` falls, and stays low until the strobes rise. `cas_n` is low for T_CAS cycles. `mem_d` equals the accepted write bit when `cas_n` falls. `d_oe` is high for exactly the T_RCD+T_CAS row-strobe-low cycles. `rd_data` is unchanged.
- R6: Read-modify-write (op 2): `cas_n` is low for T_SAMP+T_CAS cycles. `we_n` is high for the first T_SAMP of those cycles and low for the rest, so W falls after CAS. `mem_d` holds the accepted write bit when W falls. `rd_data` captures `mem_q` as in R4. `d_oe` stays low.
- R7: The two strobes rise together. `done` is a one-cycle pulse in the second cycle after `ras_n` rises. `req_ready` returns high only after T_RP precharge cycles (default 3) with both strobes high.
- R8: `req_ready` is low from acceptance until precharge ends. A `req_valid` held during that time is ignored: no second access starts and the address of the running access is not disturbed.
- R9: Op code 3 behaves exactly like a read.
- R10: After reset, `ras_n`, `cas_n` and `we_n` are high, `d_oe` and `done` are low, `req_ready` is high and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, a request is taken this cycle |
| req_op | input | 2 | 0 read, 1 early write, 2 read-modify-write, 3 read |
| req_addr | input | 18 | Cell address, row half low |
| req_wdata | input | 1 | Bit to write |
| rd_data | output | 1 | Bit last read |
| done | output | 1 | One-cycle end-of-access pulse |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ma | output | 9 | Multiplexed memory address |
| mem_d | output | 1 | Data into the memory |
| d_oe | output | 1 | Sequencer drives a shared data bus |
| mem_q | input | 1 | Data out of the memory |

## Verification
The memory's data-out pin is driven with a pattern that differs only in the cycle that should be captured. A read therefore shows whether sampling lands on the correct edge, and an early write shows whether the bus was wrongly sampled at all. Reads, early writes, read-modify-writes and op code 3 are run at address patterns whose row and column halves differ, so a swapped or shifted address field stands out. Each access is measured for strobe-low lengths, the position of W relative to CAS, the data bit seen at the write edge, the `d_oe` count, and the spacing of `done` and `req_ready` after RAS rises. A request held valid through a busy access shows whether a second access could sneak in.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_EW   = 2'd1,
    OP_RMW  = 2'd2,
    OP_RDX  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_ROW  = 3'd2,
    PH_COL  = 3'd3,
    PH_PRE  = 3'd4
  } phase_e;

  function automatic logic is_ew(op_e op);
    return op == OP_EW;
  endfunction

  function automatic logic is_rmw(op_e op);
    return op == OP_RMW;
  endfunction

  // number of cycles a phase lasts
  function automatic int unsigned phase_len(phase_e ph, op_e op,
                                            int unsigned t_rcd, int unsigned t_cas,
                                            int unsigned t_rp, int unsigned t_samp);
    case (ph)
      PH_ROW:  return t_rcd;
      PH_COL:  return is_rmw(op) ? (t_samp + t_cas) : t_cas;
      PH_PRE:  return t_rp;
      default: return 1;
    endcase
  endfunction

  // write strobe schedule: early write from row phase, RMW after sampling
  function automatic logic we_active(phase_e ph, op_e op, int unsigned idx,
                                     int unsigned t_samp);
    if (is_ew(op))  return (ph == PH_ROW) || (ph == PH_COL);
    if (is_rmw(op)) return (ph == PH_COL) && (idx >= t_samp);
    return 1'b0;
  endfunction

endpackage

// File: rtl/dseq_cnt.sv
module dseq_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (en)   q <= q + 1'b1;
  end

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_SAMP = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  op_e    op,
  output phase_e phase,
  output logic   col_sel,
  output logic   samp_evt,
  output logic   ras_n,
  output logic   cas_n,
  output logic   we_n,
  output logic   d_oe,
  output logic   done,
  output logic   ready
);

  localparam int unsigned LMAX = T_SAMP + T_CAS + T_RCD + T_RP;
  localparam int unsigned CW   = $clog2(LMAX + 1);

  phase_e          ph_q, ph_d;
  logic [CW-1:0]   idx;
  logic            ph_last;
  logic            ph_chg;
  int unsigned     len;

  assign len     = phase_len(ph_q, op, T_RCD, T_CAS, T_RP, T_SAMP);
  assign ph_last = (idx == CW'(len - 1));
  assign ph_chg  = (ph_q == PH_IDLE) ? start : ph_last;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (start)   ph_d = PH_ASET;
      PH_ASET:              ph_d = PH_ROW;
      PH_ROW:  if (ph_last) ph_d = PH_COL;
      PH_COL:  if (ph_last) ph_d = PH_PRE;
      PH_PRE:  if (ph_last) ph_d = PH_IDLE;
      default:              ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  dseq_cnt #(.W(CW)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ph_chg),
    .en    (ph_q != PH_IDLE),
    .q     (idx)
  );

  assign phase    = ph_q;
  assign ras_n    = !((ph_q == PH_ROW) || (ph_q == PH_COL));
  assign cas_n    = (ph_q != PH_COL);
  assign we_n     = !we_active(ph_q, op, 32'(idx), T_SAMP);
  assign d_oe     = is_ew(op) && !ras_n;
  assign col_sel  = (ph_q == PH_COL) || ((ph_q == PH_ROW) && ph_last);
  assign samp_evt = (ph_q == PH_COL) && (idx == CW'(T_SAMP - 1)) && !is_ew(op);
  assign done     = (ph_q == PH_PRE) && (idx == CW'(1));
  assign ready    = (ph_q == PH_IDLE);

  // R3
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R5
  oe_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !we_n);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n && $past(ras_n)));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !ready);

endmodule

// File: rtl/dseq_dpath.sv
module dseq_dpath
  import dseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  localparam int unsigned MW    = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              col_sel,
  input  logic              samp_evt,
  input  logic              mem_q,
  output op_e               cur_op,
  output logic [MW-1:0]     ma,
  output logic              mem_d,
  output logic              rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic              wd_q;
  op_e               op_q;

  function automatic logic [MW-1:0] row_of(logic [ADDR_W-1:0] a);
    return a[MW-1:0];
  endfunction

  function automatic logic [MW-1:0] col_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:MW];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= 1'b0;
      op_q   <= OP_RD;
    end else if (start) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      op_q   <= op_e'(req_op);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= 1'b0;
    else if (samp_evt) rd_data <= mem_q;
  end

  assign cur_op = op_q;
  assign ma     = col_sel ? col_of(addr_q) : row_of(addr_q);
  assign mem_d  = wd_q;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_SAMP = 2,
  localparam int unsigned MW    = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_data,
  output logic              done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [MW-1:0]     ma,
  output logic              mem_d,
  output logic              d_oe,
  input  logic              mem_q
);

  logic   start;
  logic   col_sel;
  logic   samp_evt;
  op_e    cur_op;
  phase_e phase;

  assign start = req_valid && req_ready;

  dseq_fsm #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP),
    .T_SAMP(T_SAMP)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (cur_op),
    .phase   (phase),
    .col_sel (col_sel),
    .samp_evt(samp_evt),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .d_oe    (d_oe),
    .done    (done),
    .ready   (req_ready)
  );

  dseq_dpath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .col_sel  (col_sel),
    .samp_evt (samp_evt),
    .mem_q    (mem_q),
    .cur_op   (cur_op),
    .ma       (ma),
    .mem_d    (mem_d),
    .rd_data  (rd_data)
  );

  // R2
  row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma));

  // R2
  col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ma));

  // R4
  rd_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(!cas_n));

  // R6
  late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && !cas_n) |-> $past(!cas_n));

  // R7
  strobes_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> !start);

endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;

  localparam int T_RCD  = 2;
  localparam int T_CAS  = 3;
  localparam int T_RP   = 3;
  localparam int T_SAMP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [17:0] req_addr = '0;
  logic        req_wdata = 1'b0;
  logic        rd_data, done, ras_n, cas_n, we_n, mem_d, d_oe;
  logic [8:0]  ma;
  logic        mem_q = 1'b0;
  logic        qval = 1'b1;

  always #4 clk = ~clk;

  dram_seq #(.ADDR_W(18), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_SAMP(T_SAMP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .done(done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma),
    .mem_d(mem_d), .d_oe(d_oe), .mem_q(mem_q)
  );

  int total = 0;
  int bad   = 0;

  // per-access measurements
  int m_row, m_row_pre, m_col, m_col_pre, m_rcd, m_clen, m_wfall, m_we_pre;
  int m_oe, m_wr_hit, m_wr_d, m_done_at, m_ready_at, m_cnt, m_cas_rise;
  int m_nacc = 0;
  logic m_after = 1'b0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [8:0] p_ma = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && p_ras) begin
        m_row = ma; m_row_pre = p_ma; m_rcd = 0; m_we_pre = 0; m_oe = 0;
        m_wr_hit = 0; m_wfall = -1; m_clen = 0; m_done_at = -1; m_ready_at = -1;
        m_after = 1'b0; m_nacc++;
      end
      if (!ras_n && cas_n) begin
        m_rcd++;
        if (!we_n) m_we_pre = 1;
      end
      if (!cas_n && p_cas) begin
        m_col = ma; m_col_pre = p_ma; m_clen = 0;
      end
      if (!cas_n) begin
        mem_q = (m_clen == T_SAMP - 1) ? qval : ~qval;
        if (!we_n && m_wfall < 0) m_wfall = m_clen;
        m_clen++;
      end
      if (!cas_n && !we_n && (p_cas || p_we)) begin
        m_wr_hit++; m_wr_d = mem_d;
      end
      if (d_oe) m_oe++;
      if (ras_n && !p_ras) begin
        m_after = 1'b1; m_cnt = 0; m_cas_rise = cas_n;
      end
      if (ras_n && m_after) begin
        if (done && m_done_at < 0) m_done_at = m_cnt;
        if (req_ready && m_ready_at < 0) m_ready_at = m_cnt;
        m_cnt++;
      end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ma = ma;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_access(logic [1:0] op, logic [17:0] addr, logic wd);
    int n0;
    int guard;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    n0 = m_nacc;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!(m_nacc == n0 + 1 && m_ready_at >= 0) && guard < 100) begin
      @(negedge clk); guard++;
    end
    if (guard >= 100) chk("R7", "access timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic chk_frame(string tag, logic [17:0] addr);
    chk("R1", {tag, " row"}, m_row, int'(addr[8:0]));
    chk("R1", {tag, " col"}, m_col, int'(addr[17:9]));
    chk("R2", {tag, " row before RAS"}, m_row_pre, int'(addr[8:0]));
    chk("R2", {tag, " col before CAS"}, m_col_pre, int'(addr[17:9]));
    chk("R3", {tag, " RAS-to-CAS"}, m_rcd, T_RCD);
    chk("R7", {tag, " CAS high at RAS rise"}, m_cas_rise, 1);
    chk("R7", {tag, " done position"}, m_done_at, 1);
    chk("R7", {tag, " ready after precharge"}, m_ready_at, T_RP);
  endtask

  task automatic t_reset();
    chk("R10", "ras_n", ras_n, 1);
    chk("R10", "cas_n", cas_n, 1);
    chk("R10", "we_n", we_n, 1);
    chk("R10", "d_oe", d_oe, 0);
    chk("R10", "done", done, 0);
    chk("R10", "req_ready", req_ready, 1);
    chk("R10", "rd_data", rd_data, 0);
  endtask

  task automatic t_read(logic [1:0] op, logic [17:0] addr, logic q, string req);
    qval = q;
    do_access(op, addr, ~q);
    chk_frame(req, addr);
    chk(req, "CAS low cycles", m_clen, T_CAS);
    chk(req, "W fall index", m_wfall, -1);
    chk(req, "W before CAS", m_we_pre, 0);
    chk(req, "write edges", m_wr_hit, 0);
    chk(req, "d_oe cycles", m_oe, 0);
    chk(req, "rd_data", rd_data, q);
  endtask

  task automatic t_early(logic [17:0] addr, logic d);
    logic prev;
    prev = rd_data;
    qval = ~prev;
    do_access(2'd1, addr, d);
    chk_frame("R5", addr);
    chk("R5", "W before CAS", m_we_pre, 1);
    chk("R5", "W low at CAS fall", m_wfall, 0);
    chk("R5", "CAS low cycles", m_clen, T_CAS);
    chk("R5", "write edges", m_wr_hit, 1);
    chk("R5", "D at write edge", m_wr_d, d);
    chk("R5", "d_oe cycles", m_oe, T_RCD + T_CAS);
    chk("R5", "rd_data kept", rd_data, prev);
  endtask

  task automatic t_rmw(logic [17:0] addr, logic d, logic q);
    qval = q;
    do_access(2'd2, addr, d);
    chk_frame("R6", addr);
    chk("R6", "CAS low cycles", m_clen, T_SAMP + T_CAS);
    chk("R6", "W fall index", m_wfall, T_SAMP);
    chk("R6", "W before CAS", m_we_pre, 0);
    chk("R6", "write edges", m_wr_hit, 1);
    chk("R6", "D at write edge", m_wr_d, d);
    chk("R6", "d_oe cycles", m_oe, 0);
    chk("R6", "rd_data", rd_data, q);
  endtask

  task automatic t_busy();
    logic [17:0] a;
    logic [17:0] b;
    int n0;
    a = 18'h2A5C3; b = 18'h15A3C;
    qval = 1'b1;
    while (!req_ready) @(negedge clk);
    n0 = m_nacc;
    req_valid = 1'b1; req_op = 2'd0; req_addr = a;
    @(negedge clk);
    req_op = 2'd1; req_addr = b;
    for (int i = 0; i < 4; i++) begin
      chk("R8", "ready while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk("R8", "accesses started", m_nacc, n0 + 1);
    chk("R8", "row kept", m_row, int'(a[8:0]));
    chk("R8", "col kept", m_col, int'(a[17:9]));
    chk("R8", "no write", m_wr_hit, 0);
    chk("R8", "idle ras_n", ras_n, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read(2'd0, 18'h3_FE01, 1'b1, "R4");
    t_read(2'd0, 18'h0_01FF, 1'b0, "R4");
    t_early(18'h1_5432, 1'b1);
    t_early(18'h2_A9CD, 1'b0);
    t_rmw(18'h3_0F0F, 1'b1, 1'b0);
    t_rmw(18'h0_C3A5, 1'b0, 1'b1);
    t_read(2'd3, 18'h2_4811, 1'b0, "R9");
    t_read(2'd3, 18'h1_B7EE, 1'b1, "R9");
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule